// File: doc/BRIEF.md
# Half-Bridge Gate Sequencer with Fault Priority

This block is the clocked decision logic for one power switch pair, a high side and a low side. From a direction bit and an active-high enable it picks which switch conducts. It never lets both conduct together. Every change of switch inserts a programmable dead interval during which both are off. A status selector tells the analog front end to show nothing, a current-sense level or a fault level. A fast-slew override is raised whenever a fault reaction is in progress.

The fault inputs are comparator bits that are already digital. Their voltage hysteresis is applied before they reach the block. Supply overvoltage has the highest priority and forces the high side on. Supply undervoltage comes next and parks the output with both switches off. A thermal trip is held in a latch. Only an enable-low period of a set length, taken while the thermal bit is clear, releases it. Sustained forward over-current on the conducting switch starts a switched-mode limit. The pair swaps for a fixed window and then returns, and the fault status stays up for twice that window.

The direction and enable pins are brought into the clock domain through two-flop synchronisers. All times are given as clock-cycle parameters.

Top module: `halfbridge_guard`

## Requirements
- R1: While enable is low and no supply fault is present, both gates are 0 and the status selector is 2'b00 (off). During reset, all outputs are 0.
- R2: With enable high and no fault, direction 0 drives only the low gate with status 2'b00. Direction 1 drives only the high gate with status 2'b01 (current sense).
- R3: The two gates are never 1 together. Before either gate rises, both gates have been 0 for at least DEAD_CYC cycles.
- R4: While overvoltage is 1, the high gate is 1 and the low gate is 0 once the dead interval has passed, and status is 2'b10 (error). Enable, direction and over-current inputs have no effect on the gates during this time.
- R5: While undervoltage is 1 and overvoltage is 0, both gates are 0 and status is 2'b00.
- R6: A thermal trip turns both gates off and is latched. While latched, status is 2'b10 with enable high and 2'b00 with enable low. The latch stays set after the thermal bit clears if enable stays high.
- R7: The thermal latch clears only after enable has been low for at least INH_RST_CYC synchronised cycles with the thermal bit at 0. A shorter low pulse leaves it set.
- R8: An over-current bit that is high for fewer than OC_FILT_CYC consecutive cycles has no effect on the gates or the status.
- R9: Over-current held on the conducting switch for OC_FILT_CYC cycles swaps conduction to the other switch for LIMIT_CYC cycles. The direction input is ignored during this window. After the window, the pair returns to the switch the inputs request.
- R10: A current-limit event holds status at 2'b10 for 2*LIMIT_CYC cycles from the trigger. After that, status returns to its normal value.
- R11: Enable low during a current-limit window turns both gates off.
- R12: The fast-slew output is 1 under overvoltage, undervoltage, a thermal latch or a current-limit error hold, and 0 in fault-free operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_in | input | 1 | Requested switch, 1 high side, 0 low side (asynchronous) |
| enable_in | input | 1 | Active-high enable, low means standby (asynchronous) |
| ov_flag | input | 1 | Supply above overvoltage threshold (hysteresis applied upstream) |
| uv_flag | input | 1 | Supply below undervoltage threshold (hysteresis applied upstream) |
| ot_flag | input | 1 | Junction above thermal trip |
| oc_hi | input | 1 | Forward over-current in the high switch |
| oc_lo | input | 1 | Forward over-current in the low switch |
| gate_hi | output | 1 | High-side gate enable |
| gate_lo | output | 1 | Low-side gate enable |
| status_sel | output | 2 | 00 off, 01 current sense, 10 error |
| slew_fast | output | 1 | Force fastest slew rate |

## Verification
Random combinations of enable, direction, overvoltage and undervoltage are held long enough to settle. This shows whether the priority order (overvoltage above undervoltage above standby above direction) is decoded correctly. Directed sequences cover the following cases:
- A thermal trip followed by a short enable pulse and then a long one. This separates latch hold from latch release.
- An over-current glitch shorter than the filter, compared with a sustained over-current. This separates filtering from triggering.
- Current-limit events checked inside the swap window, after it, and after the doubled error window. These separate the two timers.
- Enable dropped inside a window, and over-current under overvoltage. These show the override paths.

A running monitor checks gate exclusivity and the length of the dead interval on every gate rise.

// File: rtl/hbg_pkg.sv
// Shared encodings for the half-bridge sequencer.
package hbg_pkg;
    // Switch request handed from the fault controller to the dead-time stage.
    typedef enum logic [1:0] {
        REQ_OFF = 2'b00,
        REQ_HI  = 2'b01,
        REQ_LO  = 2'b10
    } req_e;

    // Status selector driven to the analog front end.
    typedef enum logic [1:0] {
        STAT_OFF   = 2'b00,
        STAT_SENSE = 2'b01,
        STAT_ERR   = 2'b10
    } stat_e;
endpackage

// File: rtl/hbg_sync.sv
// Multi-stage flop synchroniser for asynchronous control pins.
// Assumes each bit is independent (no bus coherence needed).
module hbg_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the asynchronous value through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d_async;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/hbg_oc_filter.sv
// Over-current spike filter: output rises once the raw bit has been high
// for FILT_CYC consecutive cycles and falls at once when it drops.
module hbg_oc_filter #(
    parameter int FILT_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_raw,
    output logic oc_valid
);
    localparam int CW = (FILT_CYC < 1) ? 1 : $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] CMAX = CW'(FILT_CYC);

    logic [CW-1:0] run_cnt;

    // Count consecutive high samples, saturating at the filter length.
    always_ff @(posedge clk) begin
        if (!rst_n)               run_cnt <= '0;
        else if (!oc_raw)         run_cnt <= '0;
        else if (run_cnt != CMAX) run_cnt <= run_cnt + 1'b1;
    end

    assign oc_valid = oc_raw && (run_cnt == CMAX);
endmodule

// File: rtl/hbg_fault_ctrl.sv
// Fault priority and protection sequencing. Decides the requested switch,
// the status selector and the fast-slew override.
// Priority: overvoltage > undervoltage > thermal > current limit > normal.
// Assumes en_s/dir_s are already synchronised and gate_hi/gate_lo are the
// registered gate outputs (used to know which switch conducts).
module hbg_fault_ctrl
    import hbg_pkg::*;
#(
    parameter int LIMIT_CYC   = 200,
    parameter int INH_RST_CYC = 40
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en_s,
    input  logic  dir_s,
    input  logic  ov,
    input  logic  uv,
    input  logic  ot,
    input  logic  ocf_hi,
    input  logic  ocf_lo,
    input  logic  gate_hi,
    input  logic  gate_lo,
    output req_e  req,
    output stat_e status,
    output logic  slew_fast
);
    localparam int WW = $clog2(2 * LIMIT_CYC + 1);
    localparam logic [WW-1:0] WIN_LOAD = WW'(LIMIT_CYC);
    localparam logic [WW-1:0] ERR_LOAD = WW'(2 * LIMIT_CYC);
    localparam int RW = (INH_RST_CYC < 1) ? 1 : $clog2(INH_RST_CYC + 1);
    localparam logic [RW-1:0] RST_MAX = RW'(INH_RST_CYC);

    logic          ot_lat;
    logic [RW-1:0] inh_cnt;
    logic [WW-1:0] win_cnt;
    logic [WW-1:0] err_cnt;
    req_e          cl_side;
    logic          ot_now;
    logic          trig;
    logic          cl_abort;
    stat_e         stat_nxt;
    logic          slew_nxt;

    assign ot_now   = ot_lat || ot;
    assign cl_abort = ov || uv || ot_now;
    // A limit event starts on filtered over-current of the conducting switch.
    assign trig = !cl_abort && en_s && (win_cnt == '0) &&
                  ((gate_hi && ocf_hi) || (gate_lo && ocf_lo));

    // Count synchronised enable-low cycles for the thermal latch release.
    always_ff @(posedge clk) begin
        if (!rst_n)                 inh_cnt <= '0;
        else if (en_s)              inh_cnt <= '0;
        else if (inh_cnt != RST_MAX) inh_cnt <= inh_cnt + 1'b1;
    end

    // Thermal latch: set on trip, cleared after a long enough low enable.
    always_ff @(posedge clk) begin
        if (!rst_n)                               ot_lat <= 1'b0;
        else if (ot)                              ot_lat <= 1'b1;
        else if (ot_lat && inh_cnt == RST_MAX)    ot_lat <= 1'b0;
    end

    // Current-limit swap window and error hold timers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt <= '0;
            err_cnt <= '0;
            cl_side <= REQ_OFF;
        end else if (cl_abort) begin
            win_cnt <= '0;
            err_cnt <= '0;
        end else if (trig) begin
            win_cnt <= WIN_LOAD;
            err_cnt <= ERR_LOAD;
            cl_side <= gate_hi ? REQ_LO : REQ_HI;
        end else begin
            if (win_cnt != '0) win_cnt <= win_cnt - 1'b1;
            if (err_cnt != '0) err_cnt <= err_cnt - 1'b1;
        end
    end

    // Select the switch request from the fault priority chain.
    always_comb begin
        if (ov)                  req = REQ_HI;
        else if (uv)             req = REQ_OFF;
        else if (ot_now)         req = REQ_OFF;
        else if (!en_s)          req = REQ_OFF;
        else if (win_cnt != '0)  req = cl_side;
        else                     req = dir_s ? REQ_HI : REQ_LO;
    end

    // Derive the next status code and slew override from the same chain.
    always_comb begin
        slew_nxt = ov || uv || ot_now || (err_cnt != '0);
        if (ov)                  stat_nxt = STAT_ERR;
        else if (uv)             stat_nxt = STAT_OFF;
        else if (ot_now)         stat_nxt = en_s ? STAT_ERR : STAT_OFF;
        else if (err_cnt != '0)  stat_nxt = STAT_ERR;
        else if (req == REQ_HI)  stat_nxt = STAT_SENSE;
        else                     stat_nxt = STAT_OFF;
    end

    // Register status outputs so the front end sees clean levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status    <= STAT_OFF;
            slew_fast <= 1'b0;
        end else begin
            status    <= stat_nxt;
            slew_fast <= slew_nxt;
        end
    end
endmodule

// File: rtl/hbg_deadtime.sv
// Dead-time insertion: on any change of request both gates drop at once,
// and the new gate rises only after DEAD_CYC further cycles with no change.
module hbg_deadtime
    import hbg_pkg::*;
#(
    parameter int DEAD_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  req_e req,
    output logic gate_hi,
    output logic gate_lo
);
    localparam int CW = (DEAD_CYC < 1) ? 1 : $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] DLOAD = CW'(DEAD_CYC);

    req_e          held;
    logic [CW-1:0] dcnt;

    // Restart the dead interval on every request change, then apply it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held    <= REQ_OFF;
            dcnt    <= '0;
            gate_hi <= 1'b0;
            gate_lo <= 1'b0;
        end else if (req != held) begin
            held    <= req;
            dcnt    <= DLOAD;
            gate_hi <= 1'b0;
            gate_lo <= 1'b0;
        end else if (dcnt != '0) begin
            dcnt    <= dcnt - 1'b1;
            gate_hi <= 1'b0;
            gate_lo <= 1'b0;
        end else begin
            gate_hi <= (held == REQ_HI);
            gate_lo <= (held == REQ_LO);
        end
    end
endmodule

// File: rtl/halfbridge_guard.sv
// Top of the half-bridge sequencer: synchronises the control pins, filters
// over-current bits, runs fault priority and inserts dead time.
// Assumes fault bits are synchronous to clk and carry their own hysteresis.
module halfbridge_guard
    import hbg_pkg::*;
#(
    parameter int DEAD_CYC    = 16,
    parameter int OC_FILT_CYC = 8,
    parameter int LIMIT_CYC   = 23000,
    parameter int INH_RST_CYC = 800,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dir_in,
    input  logic       enable_in,
    input  logic       ov_flag,
    input  logic       uv_flag,
    input  logic       ot_flag,
    input  logic       oc_hi,
    input  logic       oc_lo,
    output logic       gate_hi,
    output logic       gate_lo,
    output logic [1:0] status_sel,
    output logic       slew_fast
);
    localparam int NSW = 2;

    logic [1:0]     ctl_sync;
    logic [NSW-1:0] oc_raw;
    logic [NSW-1:0] oc_ok;
    req_e           req;
    stat_e          stat;

    hbg_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({enable_in, dir_in}),
        .q_sync  (ctl_sync)
    );

    assign oc_raw = {oc_lo, oc_hi};

    // One spike filter per switch.
    for (genvar s = 0; s < NSW; s++) begin : g_filt
        hbg_oc_filter #(.FILT_CYC(OC_FILT_CYC)) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .oc_raw   (oc_raw[s]),
            .oc_valid (oc_ok[s])
        );
    end

    hbg_fault_ctrl #(.LIMIT_CYC(LIMIT_CYC), .INH_RST_CYC(INH_RST_CYC)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_s      (ctl_sync[1]),
        .dir_s     (ctl_sync[0]),
        .ov        (ov_flag),
        .uv        (uv_flag),
        .ot        (ot_flag),
        .ocf_hi    (oc_ok[0]),
        .ocf_lo    (oc_ok[1]),
        .gate_hi   (gate_hi),
        .gate_lo   (gate_lo),
        .req       (req),
        .status    (stat),
        .slew_fast (slew_fast)
    );

    hbg_deadtime #(.DEAD_CYC(DEAD_CYC)) u_dead (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .gate_hi (gate_hi),
        .gate_lo (gate_lo)
    );

    assign status_sel = stat;
endmodule

// File: rtl/halfbridge_guard_chk.sv
// Property checker bound to halfbridge_guard.
module halfbridge_guard_chk #(
    parameter int DEAD_CYC = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ov_flag,
    input logic       uv_flag,
    input logic       ot_flag,
    input logic       gate_hi,
    input logic       gate_lo,
    input logic [1:0] status_sel,
    input logic       slew_fast
);
    localparam int CW = (DEAD_CYC < 1) ? 1 : $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] DMAX = CW'(DEAD_CYC);

    logic [CW-1:0] off_run;

    // Count cycles with both gates off, saturating at the dead length.
    always_ff @(posedge clk) begin
        if (!rst_n)                  off_run <= '0;
        else if (gate_hi || gate_lo) off_run <= '0;
        else if (off_run != DMAX)    off_run <= off_run + 1'b1;
    end

    a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi && gate_lo));
    a_r3_dead_hi: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_hi) |-> off_run == DMAX);
    a_r3_dead_lo: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_lo) |-> off_run == DMAX);
    a_r4_ov_error: assert property (@(posedge clk) disable iff (!rst_n)
        ov_flag |=> (status_sel == 2'b10) && !gate_lo);
    a_r5_uv_off: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_flag && !ov_flag) |=> (status_sel == 2'b00) && !gate_hi && !gate_lo);
    a_r6_ot_off: assert property (@(posedge clk) disable iff (!rst_n)
        (ot_flag && !ov_flag) |=> !gate_hi && !gate_lo);
    a_r12_fault_slew: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_flag || uv_flag || ot_flag) |=> slew_fast);
    a_r2_status_code: assert property (@(posedge clk) disable iff (!rst_n)
        status_sel != 2'b11);
endmodule

bind halfbridge_guard halfbridge_guard_chk #(.DEAD_CYC(DEAD_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ov_flag    (ov_flag),
    .uv_flag    (uv_flag),
    .ot_flag    (ot_flag),
    .gate_hi    (gate_hi),
    .gate_lo    (gate_lo),
    .status_sel (status_sel),
    .slew_fast  (slew_fast)
);

// File: tb/halfbridge_guard_tb.sv
`timescale 1ns/1ps
module halfbridge_guard_tb;
    localparam int DEAD  = 16;
    localparam int FILT  = 8;
    localparam int LIMIT = 200;
    localparam int RSTC  = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dir_in = 1'b0, enable_in = 1'b0;
    logic ov_flag = 1'b0, uv_flag = 1'b0, ot_flag = 1'b0;
    logic oc_hi = 1'b0, oc_lo = 1'b0;
    logic gate_hi, gate_lo, slew_fast;
    logic [1:0] status_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int off_run = 0;
    logic prev_hi = 1'b0, prev_lo = 1'b0;

    always #2.5 clk = ~clk;

    halfbridge_guard #(
        .DEAD_CYC(DEAD), .OC_FILT_CYC(FILT), .LIMIT_CYC(LIMIT),
        .INH_RST_CYC(RSTC), .SYNC_STAGES(2)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .dir_in(dir_in), .enable_in(enable_in),
        .ov_flag(ov_flag), .uv_flag(uv_flag), .ot_flag(ot_flag),
        .oc_hi(oc_hi), .oc_lo(oc_lo), .gate_hi(gate_hi), .gate_lo(gate_lo),
        .status_sel(status_sel), .slew_fast(slew_fast)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Expected settled outputs {hi, lo, status[1:0], slew} with no thermal or limit event.
    function automatic logic [4:0] settled(input logic en, input logic dir,
                                           input logic ov, input logic uv);
        if (ov)       return {1'b1, 1'b0, 2'b10, 1'b1};
        else if (uv)  return {1'b0, 1'b0, 2'b00, 1'b1};
        else if (!en) return {1'b0, 1'b0, 2'b00, 1'b0};
        else if (dir) return {1'b1, 1'b0, 2'b01, 1'b0};
        else          return {1'b0, 1'b1, 2'b00, 1'b0};
    endfunction

    task automatic chk_all(input string tag, input logic [4:0] e);
        chk({tag, " gate_hi"}, int'(gate_hi), int'(e[4]));
        chk({tag, " gate_lo"}, int'(gate_lo), int'(e[3]));
        chk({tag, " status"}, int'(status_sel), int'(e[2:1]));
        chk({tag, " slew"}, int'(slew_fast), int'(e[0]));
    endtask

    // R3 monitor: exclusivity and dead interval before every gate rise.
    always @(negedge clk) begin
        if (rst_n) begin
            if (gate_hi && gate_lo) chk("R3 overlap", 1, 0);
            if ((gate_hi && !prev_hi) || (gate_lo && !prev_lo))
                chk("R3 dead interval ok", int'(off_run >= DEAD), 1);
            off_run = (gate_hi || gate_lo) ? 0 : off_run + 1;
        end
        prev_hi = gate_hi;
        prev_lo = gate_lo;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0042);
        // R1: reset state
        wait_cyc(4);
        chk_all("R1 reset", 5'b00000);
        @(negedge clk) rst_n = 1'b1;
        wait_cyc(5);
        chk_all("R1 standby", settled(1'b0, 1'b0, 1'b0, 1'b0));

        // Random settled patterns: R1 R2 R4 R5 R12 priority decoding.
        for (int i = 0; i < 30; i++) begin
            enable_in = 1'($urandom);
            dir_in    = 1'($urandom);
            ov_flag   = ($urandom % 5) == 0;
            uv_flag   = ($urandom % 4) == 0;
            wait_cyc(40);
            chk_all("R2 R4 R5 random", settled(enable_in, dir_in, ov_flag, uv_flag));
        end
        ov_flag = 1'b0; uv_flag = 1'b0;

        // R4: overvoltage forces high side even in standby; limit disabled.
        enable_in = 1'b0;
        ov_flag = 1'b1;
        wait_cyc(40);
        chk_all("R4 ov standby", 5'b10101);
        oc_hi = 1'b1;
        wait_cyc(40);
        chk_all("R4 ov ignores oc", 5'b10101);
        oc_hi = 1'b0; ov_flag = 1'b0;
        wait_cyc(40);
        chk_all("R1 after ov", 5'b00000);

        // R5: undervoltage with enable high.
        enable_in = 1'b1; dir_in = 1'b0;
        uv_flag = 1'b1;
        wait_cyc(40);
        chk_all("R5 R12 uv", 5'b00001);
        uv_flag = 1'b0;
        wait_cyc(40);
        chk_all("R2 low side", 5'b01000);

        // R6/R7: thermal latch hold and release.
        dir_in = 1'b1;
        wait_cyc(40);
        chk_all("R2 high side", 5'b10010);
        ot_flag = 1'b1;
        wait_cyc(5);
        ot_flag = 1'b0;
        wait_cyc(40);
        chk_all("R6 latched en high", 5'b00101);
        enable_in = 1'b0;
        wait_cyc(10);
        enable_in = 1'b1;
        wait_cyc(40);
        chk_all("R7 short pulse keeps latch", 5'b00101);
        enable_in = 1'b0;
        wait_cyc(20);
        chk_all("R6 latched en low", 5'b00001);
        wait_cyc(40);
        enable_in = 1'b1;
        wait_cyc(40);
        chk_all("R7 released", 5'b10010);

        // R8: over-current glitch shorter than the filter.
        oc_hi = 1'b1;
        wait_cyc(FILT - 3);
        oc_hi = 1'b0;
        wait_cyc(40);
        chk_all("R8 glitch ignored", 5'b10010);

        // R9/R10/R12: limit event on the high side, direction held at 1.
        oc_hi = 1'b1;
        wait_cyc(10);
        oc_hi = 1'b0;
        wait_cyc(110);
        chk_all("R9 R10 R12 swapped", 5'b01101);
        wait_cyc(140);
        chk_all("R9 returned R10 held", 5'b10101);
        wait_cyc(180);
        chk_all("R10 error released", 5'b10010);

        // R9: low-side event; direction stays 0 but the high side conducts.
        dir_in = 1'b0;
        wait_cyc(40);
        oc_lo = 1'b1;
        wait_cyc(10);
        oc_lo = 1'b0;
        wait_cyc(110);
        chk_all("R9 dir ignored", 5'b10101);
        wait_cyc(340);
        chk_all("R9 R10 lo end", 5'b01000);

        // R11: enable low inside a window drops both gates.
        dir_in = 1'b1;
        wait_cyc(40);
        oc_hi = 1'b1;
        wait_cyc(10);
        oc_hi = 1'b0;
        wait_cyc(50);
        enable_in = 1'b0;
        wait_cyc(30);
        chk_all("R11 inhibit in window", 5'b00101);
        enable_in = 1'b1;
        wait_cyc(40);
        chk_all("R11 window resumes", 5'b01101);
        wait_cyc(330);
        chk_all("R11 normal again", 5'b10010);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule